// File: doc/BRIEF.md
# Thermal Throttle DVFS Sequencer

This block lowers the core operating point when a digital die-temperature sample reaches a programmable trip level, and otherwise follows the operating point that software asks for. An operating point is a pair: a frequency ratio and a voltage code. The trip level is taken from a 32-bit configuration word. The word holds a maximum junction temperature and an offset that is subtracted from it. The throttled operating point comes from a lookup input that is supplied from outside. Protection is always on, and no bit of the word can disable it.

Software requests are arbitrated against the throttled point. While the throttle is active, a request at or below the throttled ratio takes effect at once. A request above it is parked and takes effect when the throttle releases. The resolved target is then reached by a sequencer that talks to a voltage regulator and a clock generator. Each side uses a request/acknowledge pair.

The sequencer has five states:
- `ST_IDLE` compares the target with the applied point and starts a sequence when they differ.
- `ST_VOLT_LEAD` raises the voltage first on an upward move (ratio increases).
- `ST_FREQ_TRAIL` then changes the frequency.
- `ST_FREQ_LEAD` lowers the frequency first on a downward move.
- `ST_VOLT_TRAIL` then changes the voltage. A change of voltage code alone also uses this state.

Transitions:
- `IDLE->VOLT_LEAD`: ratio up and voltage differs.
- `IDLE->FREQ_TRAIL`: ratio up and same voltage.
- `IDLE->FREQ_LEAD`: ratio down.
- `IDLE->VOLT_TRAIL`: same ratio, voltage differs.
- `VOLT_LEAD->FREQ_TRAIL`, `FREQ_LEAD->VOLT_TRAIL`, `VOLT_LEAD->IDLE`, `FREQ_LEAD->IDLE`, `FREQ_TRAIL->IDLE` and `VOLT_TRAIL->IDLE`: each is taken on the matching acknowledge.

Execution halt is raised only in the two frequency states.

Top module: `thermal_dvfs_seq`

## Requirements
- R1: The trip level is cfg[23:16] minus cfg[29:24], saturating at 0. A valid temperature sample equal to or above the trip level sets `throttle_o` in the cycle after the sample, and a sample one below it does not.
- R2: With an offset field of 0, the throttle trips exactly at the maximum junction temperature in cfg[23:16].
- R3: An active throttle releases only on a sample at or below the trip level minus HYST (default 3). A sample one degree above that keeps it active.
- R4: While the throttle is active and the applied software ratio is above `therm_ratio_i`, the target becomes the point (`therm_ratio_i`, `therm_vcode_i`).
- R5: On a move to a higher ratio, the voltage request is acknowledged before the frequency request starts.
- R6: On a move to a lower ratio, the frequency request is acknowledged before the voltage request starts.
- R7: `halt_o` is high exactly while a frequency request is outstanding, and never during a voltage request.
- R8: A software request whose ratio is above `therm_ratio_i` while the throttle is active is held, and it is applied once the throttle releases.
- R9: A software request whose ratio is at or below `therm_ratio_i` while the throttle is active is applied at once.
- R10: When the throttle releases, the outputs return to the software-requested point.
- R11: Each request is held with a stable value until acknowledged, and only one request is outstanding at a time. A target that changes mid-sequence is applied after the current sequence completes.
- R12: After reset, the outputs show ratio RST_RATIO (20) and voltage code RST_VCODE (40), with no request, no halt and no throttle.
- R13: cfg[31:30] and cfg[15:0] have no effect, and no setting disables the throttle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_i | input | 8 | Die temperature sample, degrees |
| temp_valid_i | input | 1 | Sample strobe |
| cfg_i | input | 32 | Maximum temperature [23:16], offset [29:24] |
| sw_valid_i | input | 1 | Software request strobe |
| sw_ratio_i | input | 8 | Requested frequency ratio |
| sw_vcode_i | input | 8 | Requested voltage code |
| therm_ratio_i | input | 8 | Throttled ratio from lookup |
| therm_vcode_i | input | 8 | Throttled voltage code from lookup |
| vreg_req_o | output | 1 | Voltage change request |
| vreg_code_o | output | 8 | Voltage code, target while requesting |
| vreg_ack_i | input | 1 | Regulator acknowledge |
| clk_req_o | output | 1 | Frequency change request |
| clk_ratio_o | output | 8 | Ratio, target while requesting |
| clk_ack_i | input | 1 | Clock generator acknowledge |
| halt_o | output | 1 | Execution halt |
| throttle_o | output | 1 | Thermal throttle active |

## Verification
The assertions check on every cycle that requests keep a stable value until acknowledged, that the two requests never overlap, and that halt covers only frequency requests. They also check that the throttle changes only after a temperature sample. Only the bench scenarios can show the trip and release levels, the order of voltage and frequency on upward and downward moves, and the parking of requests above the throttled point. The same holds for the deferred application of a target that arrives mid-sequence.

// File: rtl/thermal_dvfs_pkg.sv
package thermal_dvfs_pkg;
    parameter int RATIO_W = 8;
    parameter int VCODE_W = 8;
    parameter int TEMP_W  = 8;
    parameter int CFG_W   = 32;
    parameter int TJ_LSB  = 16;
    parameter int TJ_W    = 8;
    parameter int OFS_LSB = 24;
    parameter int OFS_W   = 6;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [VCODE_W-1:0] vcode;
    } op_point_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VOLT_LEAD,
        ST_FREQ_TRAIL,
        ST_FREQ_LEAD,
        ST_VOLT_TRAIL
    } seq_state_t;
endpackage

// File: rtl/thermal_trip.sv
module thermal_trip
    import thermal_dvfs_pkg::*;
#(
    parameter int HYST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              temp_valid_i,
    input  logic [CFG_W-1:0]  cfg_i,
    output logic              throttle_o
);
    localparam int THR_W = ((TEMP_W > TJ_W) ? TEMP_W : TJ_W) + 2;

    logic [THR_W-1:0] tj_max;
    logic [THR_W-1:0] offset;
    logic [THR_W-1:0] trip_lvl;
    logic [THR_W-1:0] temp_ext;
    logic             hot;
    logic             cool;

    assign tj_max   = THR_W'(cfg_i[TJ_LSB +: TJ_W]);
    assign offset   = THR_W'(cfg_i[OFS_LSB +: OFS_W]);
    assign trip_lvl = (offset > tj_max) ? '0 : (tj_max - offset);
    assign temp_ext = THR_W'(temp_i);
    assign hot      = temp_ext >= trip_lvl;
    assign cool     = (temp_ext + THR_W'(HYST)) <= trip_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            throttle_o <= 1'b0;
        end else if (temp_valid_i) begin
            if (!throttle_o && hot) begin
                throttle_o <= 1'b1;
            end else if (throttle_o && cool) begin
                throttle_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/target_arbiter.sv
module target_arbiter
    import thermal_dvfs_pkg::*;
#(
    parameter op_point_t RST_POINT = '0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      throttle_i,
    input  logic      sw_valid_i,
    input  op_point_t sw_point_i,
    input  op_point_t therm_point_i,
    output op_point_t target_o
);
    op_point_t granted;
    op_point_t parked;
    logic      parked_vld;
    logic      above_ceiling;

    assign above_ceiling = sw_point_i.ratio > therm_point_i.ratio;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            granted    <= RST_POINT;
            parked     <= RST_POINT;
            parked_vld <= 1'b0;
        end else if (sw_valid_i) begin
            if (throttle_i && above_ceiling) begin
                parked     <= sw_point_i;
                parked_vld <= 1'b1;
            end else begin
                granted    <= sw_point_i;
                parked_vld <= 1'b0;
            end
        end else if (!throttle_i && parked_vld) begin
            granted    <= parked;
            parked_vld <= 1'b0;
        end
    end

    always_comb begin
        if (throttle_i && (granted.ratio > therm_point_i.ratio)) begin
            target_o = therm_point_i;
        end else if (!throttle_i && parked_vld) begin
            target_o = parked;
        end else begin
            target_o = granted;
        end
    end
endmodule

// File: rtl/dvfs_step_fsm.sv
module dvfs_step_fsm
    import thermal_dvfs_pkg::*;
#(
    parameter op_point_t RST_POINT = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  op_point_t          target_i,
    input  logic               vreg_ack_i,
    input  logic               clk_ack_i,
    output logic               vreg_req_o,
    output logic [VCODE_W-1:0] vreg_code_o,
    output logic               clk_req_o,
    output logic [RATIO_W-1:0] clk_ratio_o,
    output logic               halt_o
);
    seq_state_t state;
    seq_state_t state_nx;
    op_point_t  applied;
    op_point_t  goal;
    logic       volt_done;
    logic       freq_done;

    assign volt_done = vreg_req_o && vreg_ack_i;
    assign freq_done = clk_req_o && clk_ack_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (target_i.ratio > applied.ratio) begin
                    state_nx = (target_i.vcode != applied.vcode) ? ST_VOLT_LEAD : ST_FREQ_TRAIL;
                end else if (target_i.ratio < applied.ratio) begin
                    state_nx = ST_FREQ_LEAD;
                end else if (target_i.vcode != applied.vcode) begin
                    state_nx = ST_VOLT_TRAIL;
                end
            end
            ST_VOLT_LEAD: begin
                if (vreg_ack_i) begin
                    state_nx = (goal.ratio != applied.ratio) ? ST_FREQ_TRAIL : ST_IDLE;
                end
            end
            ST_FREQ_TRAIL: begin
                if (clk_ack_i) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_FREQ_LEAD: begin
                if (clk_ack_i) begin
                    state_nx = (goal.vcode != applied.vcode) ? ST_VOLT_TRAIL : ST_IDLE;
                end
            end
            ST_VOLT_TRAIL: begin
                if (vreg_ack_i) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        vreg_req_o  = 1'b0;
        clk_req_o   = 1'b0;
        halt_o      = 1'b0;
        vreg_code_o = applied.vcode;
        clk_ratio_o = applied.ratio;
        unique case (state)
            ST_IDLE: begin
            end
            ST_VOLT_LEAD, ST_VOLT_TRAIL: begin
                vreg_req_o  = 1'b1;
                vreg_code_o = goal.vcode;
            end
            ST_FREQ_LEAD, ST_FREQ_TRAIL: begin
                clk_req_o   = 1'b1;
                halt_o      = 1'b1;
                clk_ratio_o = goal.ratio;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            applied <= RST_POINT;
            goal    <= RST_POINT;
        end else begin
            if (state == ST_IDLE) begin
                goal <= target_i;
            end
            if (volt_done) begin
                applied.vcode <= goal.vcode;
            end
            if (freq_done) begin
                applied.ratio <= goal.ratio;
            end
        end
    end
endmodule

// File: rtl/thermal_dvfs_seq.sv
module thermal_dvfs_seq
    import thermal_dvfs_pkg::*;
#(
    parameter int HYST      = 3,
    parameter int RST_RATIO = 20,
    parameter int RST_VCODE = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TEMP_W-1:0]  temp_i,
    input  logic               temp_valid_i,
    input  logic [CFG_W-1:0]   cfg_i,
    input  logic               sw_valid_i,
    input  logic [RATIO_W-1:0] sw_ratio_i,
    input  logic [VCODE_W-1:0] sw_vcode_i,
    input  logic [RATIO_W-1:0] therm_ratio_i,
    input  logic [VCODE_W-1:0] therm_vcode_i,
    output logic               vreg_req_o,
    output logic [VCODE_W-1:0] vreg_code_o,
    input  logic               vreg_ack_i,
    output logic               clk_req_o,
    output logic [RATIO_W-1:0] clk_ratio_o,
    input  logic               clk_ack_i,
    output logic               halt_o,
    output logic               throttle_o
);
    localparam op_point_t RST_POINT = '{ratio: RATIO_W'(RST_RATIO), vcode: VCODE_W'(RST_VCODE)};

    op_point_t sw_point;
    op_point_t therm_point;
    op_point_t target;

    assign sw_point    = '{ratio: sw_ratio_i, vcode: sw_vcode_i};
    assign therm_point = '{ratio: therm_ratio_i, vcode: therm_vcode_i};

    thermal_trip #(
        .HYST(HYST)
    ) u_trip (
        .clk         (clk),
        .rst_n       (rst_n),
        .temp_i      (temp_i),
        .temp_valid_i(temp_valid_i),
        .cfg_i       (cfg_i),
        .throttle_o  (throttle_o)
    );

    target_arbiter #(
        .RST_POINT(RST_POINT)
    ) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .throttle_i   (throttle_o),
        .sw_valid_i   (sw_valid_i),
        .sw_point_i   (sw_point),
        .therm_point_i(therm_point),
        .target_o     (target)
    );

    dvfs_step_fsm #(
        .RST_POINT(RST_POINT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .target_i   (target),
        .vreg_ack_i (vreg_ack_i),
        .clk_ack_i  (clk_ack_i),
        .vreg_req_o (vreg_req_o),
        .vreg_code_o(vreg_code_o),
        .clk_req_o  (clk_req_o),
        .clk_ratio_o(clk_ratio_o),
        .halt_o     (halt_o)
    );
endmodule

// File: rtl/thermal_dvfs_seq_chk.sv
module thermal_dvfs_seq_chk
    import thermal_dvfs_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               temp_valid_i,
    input logic               vreg_req_o,
    input logic [VCODE_W-1:0] vreg_code_o,
    input logic               vreg_ack_i,
    input logic               clk_req_o,
    input logic [RATIO_W-1:0] clk_ratio_o,
    input logic               clk_ack_i,
    input logic               halt_o,
    input logic               throttle_o
);
    p_vreq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vreg_req_o && !vreg_ack_i) |=> (vreg_req_o && $stable(vreg_code_o)));

    p_creq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_req_o && !clk_ack_i) |=> (clk_req_o && $stable(clk_ratio_o)));

    p_single_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({vreg_req_o, clk_req_o}) <= 1);

    p_no_halt_volt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vreg_req_o |-> !halt_o);

    p_halt_freq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> clk_req_o);

    p_trip_on_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(throttle_o) |-> $past(temp_valid_i));

    p_release_on_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(throttle_o) |-> $past(temp_valid_i));
endmodule

bind thermal_dvfs_seq thermal_dvfs_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .temp_valid_i(temp_valid_i),
    .vreg_req_o  (vreg_req_o),
    .vreg_code_o (vreg_code_o),
    .vreg_ack_i  (vreg_ack_i),
    .clk_req_o   (clk_req_o),
    .clk_ratio_o (clk_ratio_o),
    .clk_ack_i   (clk_ack_i),
    .halt_o      (halt_o),
    .throttle_o  (throttle_o)
);

// File: tb/thermal_dvfs_seq_test.sv
`timescale 1ns/1ps
module thermal_dvfs_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] temp_i = '0;
    logic       temp_valid_i = 1'b0;
    logic [31:0] cfg_i = 32'h0064_0000;
    logic       sw_valid_i = 1'b0;
    logic [7:0] sw_ratio_i = '0;
    logic [7:0] sw_vcode_i = '0;
    logic [7:0] therm_ratio_i = 8'd10;
    logic [7:0] therm_vcode_i = 8'd25;
    logic       vreg_req_o;
    logic [7:0] vreg_code_o;
    logic       vreg_ack_i = 1'b0;
    logic       clk_req_o;
    logic [7:0] clk_ratio_o;
    logic       clk_ack_i = 1'b0;
    logic       halt_o;
    logic       throttle_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int v_ack_cyc = 0;
    int f_ack_cyc = 0;
    int halt_bad = 0;
    int halt_seen = 0;
    int vcnt = 0;
    int fcnt = 0;
    bit saw_mid = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    thermal_dvfs_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .temp_i       (temp_i),
        .temp_valid_i (temp_valid_i),
        .cfg_i        (cfg_i),
        .sw_valid_i   (sw_valid_i),
        .sw_ratio_i   (sw_ratio_i),
        .sw_vcode_i   (sw_vcode_i),
        .therm_ratio_i(therm_ratio_i),
        .therm_vcode_i(therm_vcode_i),
        .vreg_req_o   (vreg_req_o),
        .vreg_code_o  (vreg_code_o),
        .vreg_ack_i   (vreg_ack_i),
        .clk_req_o    (clk_req_o),
        .clk_ratio_o  (clk_ratio_o),
        .clk_ack_i    (clk_ack_i),
        .halt_o       (halt_o),
        .throttle_o   (throttle_o)
    );

    // regulator / clock generator model and protocol monitor
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (halt_o != clk_req_o) halt_bad <= halt_bad + 1;
            if (vreg_req_o && halt_o) halt_bad <= halt_bad + 1;
            if (halt_o) halt_seen <= halt_seen + 1;
        end
        if (vreg_ack_i) begin
            vreg_ack_i <= 1'b0;
        end else if (vreg_req_o) begin
            if (vcnt == 1) begin
                vreg_ack_i <= 1'b1;
                vcnt <= 0;
                v_ack_cyc <= cyc;
            end else begin
                vcnt <= vcnt + 1;
            end
        end
        if (clk_ack_i) begin
            clk_ack_i <= 1'b0;
        end else if (clk_req_o) begin
            if (fcnt == 1) begin
                clk_ack_i <= 1'b1;
                fcnt <= 0;
                f_ack_cyc <= cyc;
                if (clk_ratio_o == 8'd30) saw_mid <= 1'b1;
            end else begin
                fcnt <= fcnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sample_temp(input int t);
        @(negedge clk);
        temp_i = 8'(t);
        temp_valid_i = 1'b1;
        @(negedge clk);
        temp_valid_i = 1'b0;
    endtask

    task automatic sw_request(input int r, input int v);
        @(negedge clk);
        sw_ratio_i = 8'(r);
        sw_vcode_i = 8'(v);
        sw_valid_i = 1'b1;
        @(negedge clk);
        sw_valid_i = 1'b0;
    endtask

    task automatic settle();
        int quiet = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (!vreg_req_o && !clk_req_o) quiet++;
            else quiet = 0;
            if (quiet >= 4) break;
        end
    endtask

    task automatic expect_point(input string tag, input int r, input int v);
        check(clk_ratio_o == 8'(r), {tag, " ratio"}, clk_ratio_o, r);
        check(vreg_code_o == 8'(v), {tag, " vcode"}, vreg_code_o, v);
    endtask

    task automatic t_reset();
        check(!throttle_o && !vreg_req_o && !clk_req_o && !halt_o, "R12 idle flags",
              {throttle_o, vreg_req_o, clk_req_o, halt_o}, 0);
        expect_point("R12 reset point", 20, 40);
    endtask

    task automatic t_up_order();
        v_ack_cyc = 0;
        f_ack_cyc = 0;
        sw_request(30, 55);
        settle();
        expect_point("R5 up point", 30, 55);
        check(v_ack_cyc > 0 && v_ack_cyc < f_ack_cyc, "R5 voltage acked first", v_ack_cyc, f_ack_cyc);
    endtask

    task automatic t_down_order();
        v_ack_cyc = 0;
        f_ack_cyc = 0;
        sw_request(15, 30);
        settle();
        expect_point("R6 down point", 15, 30);
        check(f_ack_cyc > 0 && f_ack_cyc < v_ack_cyc, "R6 frequency acked first", f_ack_cyc, v_ack_cyc);
    endtask

    task automatic t_default_trip();
        cfg_i = 32'h0064_0000;
        sample_temp(99);
        check(throttle_o == 1'b0, "R2 below tjmax", throttle_o, 0);
        sample_temp(100);
        check(throttle_o == 1'b1, "R2 at tjmax", throttle_o, 1);
        settle();
        expect_point("R4 throttled point", 10, 25);
        sample_temp(98);
        check(throttle_o == 1'b1, "R3 inside hysteresis", throttle_o, 1);
        sample_temp(97);
        check(throttle_o == 1'b0, "R3 release", throttle_o, 0);
        settle();
        expect_point("R10 back to request", 15, 30);
    endtask

    task automatic t_offset_trip();
        cfg_i = 32'hD464_FFFF;
        sample_temp(79);
        check(throttle_o == 1'b0, "R1 one below trip", throttle_o, 0);
        sample_temp(80);
        check(throttle_o == 1'b1, "R1 R13 at trip with stray cfg bits", throttle_o, 1);
        settle();
        expect_point("R4 throttled via offset", 10, 25);
    endtask

    task automatic t_deferred();
        sw_request(40, 60);
        settle();
        expect_point("R8 held while hot", 10, 25);
        sample_temp(77);
        check(throttle_o == 1'b0, "R3 release at offset trip", throttle_o, 0);
        settle();
        expect_point("R8 applied after release", 40, 60);
    endtask

    task automatic t_lower_now();
        sample_temp(90);
        settle();
        expect_point("R4 throttled again", 10, 25);
        sw_request(8, 20);
        settle();
        check(throttle_o == 1'b1, "R9 still throttled", throttle_o, 1);
        expect_point("R9 lower applied", 8, 20);
        sample_temp(50);
        settle();
        expect_point("R10 lower kept", 8, 20);
    endtask

    task automatic t_mid_sequence();
        saw_mid = 1'b0;
        sw_request(30, 50);
        for (int i = 0; i < 50; i++) begin
            if (vreg_req_o) break;
            @(negedge clk);
        end
        sw_request(12, 35);
        settle();
        check(saw_mid == 1'b1, "R11 first sequence finished", saw_mid, 1);
        expect_point("R11 latched target", 12, 35);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_up_order();
        t_down_order();
        t_default_trip();
        t_offset_trip();
        t_deferred();
        t_lower_now();
        t_mid_sequence();
        check(halt_bad == 0, "R7 halt only during frequency step", halt_bad, 0);
        check(halt_seen > 0, "R7 halt seen", halt_seen, 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule